// File: doc/BRIEF.md
# Phase-Multiplexed Bank Address Demultiplexer

This block joins a processor that time-shares its eight data pins with a system bus that has separate address and data lines. In the first half of every bus cycle (phase clock low) the shared pins present the top eight address bits, called the bank byte. In the second half (phase clock high) the same pins carry data. The block captures the bank byte during the first half and joins it to the sixteen dedicated low address lines, so the system bus sees one stable 24-bit address for the whole cycle.

The data path works as a transceiver controller. It is enabled only in the second half of a cycle that carries a valid-data or valid-program-address strobe. It passes memory data towards the processor on a read and processor data towards memory on a write. In the first half it drives neither side, so a memory that answers early cannot collide with the bank byte on the shared pins. Pads are outside the block: each bidirectional side is split into an input, an output and an output enable. A low enable means that side is tri-stated. The phase clock is sampled on a faster system clock `clk`. The reset is asynchronous, active low, and released synchronously.

Top module: `bank_addr_demux`

## Requirements
- R1: While the phase clock is low and reset has been released, `sys_addr[23:16]` equals `cpu_d_in` (the bank latch is transparent).
- R2: While the phase clock is high, `sys_addr[23:16]` holds the `cpu_d_in` value sampled at the last `clk` rising edge at which the phase clock was low. Changes on `cpu_d_in` during the high phase have no effect on it.
- R3: `sys_addr[15:0]` always equals `addr_lo`.
- R4: A read is `rw_n` = 1. In the high phase of a valid read, `cpu_d_oe` = 1, `cpu_d_out` = `sys_d_in` and `sys_d_oe` = 0.
- R5: A write is `rw_n` = 0. In the high phase of a valid write, `sys_d_oe` = 1, `sys_d_out` = `cpu_d_in` and `cpu_d_oe` = 0.
- R6: While the phase clock is low, both `cpu_d_oe` and `sys_d_oe` are 0, whatever the values of `rw_n`, the strobes and `sys_d_in`.
- R7: When neither `vda` nor `vpa` is 1, both output enables and `mem_cs` are 0.
- R8: Once reset has been released, `mem_cs` is 1 whenever `vda` or `vpa` is 1. Either strobe alone is enough.
- R9: While reset is asserted, and for the synchronizer stages after its release, `mem_cs` and both output enables are 0 and the bank byte reads zero. After release, the bank byte stays zero until the first capture.
- R10: `cpu_d_oe` and `sys_d_oe` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Phase clock: low = bank byte phase, high = data phase |
| rw_n | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Valid data address strobe |
| vpa | input | 1 | Valid program address strobe |
| addr_lo | input | 16 | Dedicated low address lines |
| cpu_d_in | input | 8 | Value seen on the shared processor pins |
| cpu_d_out | output | 8 | Read data driven to the shared processor pins |
| cpu_d_oe | output | 1 | Output enable for the processor side |
| sys_d_in | input | 8 | Value seen on the system data bus |
| sys_d_out | output | 8 | Write data driven to the system data bus |
| sys_d_oe | output | 1 | Output enable for the system side |
| sys_addr | output | 24 | Full demultiplexed address |
| mem_cs | output | 1 | Memory chip select |

## Verification
The assertions check on every cycle that the two drive enables never overlap, that the first phase drives neither side, that an idle cycle selects nothing, that a valid read or write turns on the correct side, and that the bank byte stays put across consecutive data-phase samples. Only the bench scenarios can show that the value held is the right one. It must be the byte from the first phase, not one the processor put on its pins later. The scenarios also show that data crosses in the right direction with the right value, and that the bank byte reads zero after reset before any capture.

// File: rtl/bank_demux_pkg.sv
package bank_demux_pkg;

  typedef enum logic {
    XFER_WRITE = 1'b0,
    XFER_READ  = 1'b1
  } xfer_dir_e;

  function automatic logic strobe_valid(input logic data_strobe, input logic prog_strobe);
    return data_strobe | prog_strobe;
  endfunction

endpackage

// File: rtl/bdm_reset_sync.sv
module bdm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign run = chain_q[STAGES-1];
endmodule

// File: rtl/bdm_bank_latch.sv
module bdm_bank_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         phi2,
  input  logic [W-1:0] pins,
  output logic [W-1:0] bank
);
  logic         cap_en;
  logic         see_through;
  logic [W-1:0] bank_q;
  logic [W-1:0] bank_d;

  assign cap_en      = run & ~phi2;
  assign see_through = run & ~phi2;

  always_comb begin
    bank_d = bank_q;
    if (cap_en) bank_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign bank = see_through ? pins : bank_q;

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!run)
    (phi2 && $past(phi2) && $past(run)) |-> $stable(bank)) else $error("bank moved in data phase"); // R2
endmodule

// File: rtl/bdm_xcvr_ctrl.sv
module bdm_xcvr_ctrl
  import bank_demux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         run,
  input  logic         phi2,
  input  logic         rw_n,
  input  logic         vda,
  input  logic         vpa,
  input  logic [W-1:0] cpu_in,
  input  logic [W-1:0] sys_in,
  output logic [W-1:0] cpu_out,
  output logic         cpu_oe,
  output logic [W-1:0] sys_out,
  output logic         sys_oe,
  output logic         cs
);
  xfer_dir_e dir;
  logic      valid;
  logic      xcvr_en;

  assign dir     = xfer_dir_e'(rw_n);
  assign valid   = strobe_valid(vda, vpa);
  assign xcvr_en = run & phi2 & valid;
  assign cs      = run & valid;

  always_comb begin
    cpu_oe = 1'b0;
    sys_oe = 1'b0;
    if (xcvr_en) begin
      if (dir == XFER_READ) cpu_oe = 1'b1;
      else                  sys_oe = 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_lane
      assign cpu_out[gi] = sys_in[gi];
      assign sys_out[gi] = cpu_in[gi];
    end
  endgenerate

  AST_PH1_ISOLATE: assert property (@(posedge clk) disable iff (!run)
    !phi2 |-> (!cpu_oe && !sys_oe)) else $error("drive in bank phase"); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!run)
    !(vda || vpa) |-> (!cs && !cpu_oe && !sys_oe)) else $error("idle cycle active"); // R7
  AST_RD_DRIVE: assert property (@(posedge clk) disable iff (!run)
    (phi2 && (vda || vpa) && rw_n) |-> (cpu_oe && !sys_oe)) else $error("read drive wrong"); // R4
  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!run)
    (phi2 && (vda || vpa) && !rw_n) |-> (sys_oe && !cpu_oe)) else $error("write drive wrong"); // R5
  AST_OE_EXCL: assert property (@(posedge clk) disable iff (!run)
    !(cpu_oe && sys_oe)) else $error("both sides driven"); // R10
endmodule

// File: rtl/bank_addr_demux.sv
module bank_addr_demux #(
  parameter int BANK_W      = 8,
  parameter int LOW_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    phi2,
  input  logic                    rw_n,
  input  logic                    vda,
  input  logic                    vpa,
  input  logic [LOW_W-1:0]        addr_lo,
  input  logic [BANK_W-1:0]       cpu_d_in,
  output logic [BANK_W-1:0]       cpu_d_out,
  output logic                    cpu_d_oe,
  input  logic [BANK_W-1:0]       sys_d_in,
  output logic [BANK_W-1:0]       sys_d_out,
  output logic                    sys_d_oe,
  output logic [BANK_W+LOW_W-1:0] sys_addr,
  output logic                    mem_cs
);
  localparam int ADDR_W = BANK_W + LOW_W;

  logic              run;
  logic [BANK_W-1:0] bank;

  bdm_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  bdm_bank_latch #(.W(BANK_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .phi2  (phi2),
    .pins  (cpu_d_in),
    .bank  (bank)
  );

  bdm_xcvr_ctrl #(.W(BANK_W)) u_xcvr (
    .clk     (clk),
    .run     (run),
    .phi2    (phi2),
    .rw_n    (rw_n),
    .vda     (vda),
    .vpa     (vpa),
    .cpu_in  (cpu_d_in),
    .sys_in  (sys_d_in),
    .cpu_out (cpu_d_out),
    .cpu_oe  (cpu_d_oe),
    .sys_out (sys_d_out),
    .sys_oe  (sys_d_oe),
    .cs      (mem_cs)
  );

  assign sys_addr = {bank, addr_lo};

  AST_CS_VALID: assert property (@(posedge clk) disable iff (!run)
    (vda || vpa) |-> mem_cs) else $error("chip select missing"); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!run)
    (phi2 && $past(phi2) && $past(run)) |-> $stable(sys_addr[ADDR_W-1:LOW_W])) else $error("address bank moved"); // R2
endmodule

// File: tb/bank_addr_demux_test.sv
`timescale 1ns/1ps
module bank_addr_demux_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        phi2, rw_n, vda, vpa;
  logic [15:0] addr_lo;
  logic [7:0]  cpu_d_in, sys_d_in;
  logic [7:0]  cpu_d_out, sys_d_out;
  logic        cpu_d_oe, sys_d_oe, mem_cs;
  logic [23:0] sys_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_addr_demux uut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw_n(rw_n), .vda(vda), .vpa(vpa),
    .addr_lo(addr_lo), .cpu_d_in(cpu_d_in), .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe),
    .sys_d_in(sys_d_in), .sys_d_out(sys_d_out), .sys_d_oe(sys_d_oe),
    .sys_addr(sys_addr), .mem_cs(mem_cs)
  );

  // fields: rw_n, vda, vpa, bank[8], lo[16], wdata[8], rdata[8]
  localparam logic [42:0] VEC [0:6] = '{
    {1'b1, 1'b1, 1'b0, 8'hA5, 16'h1234, 8'h00, 8'hC3},
    {1'b0, 1'b1, 1'b0, 8'h3C, 16'hBEEF, 8'h96, 8'h11},
    {1'b1, 1'b0, 1'b1, 8'hFF, 16'h0000, 8'h00, 8'h7E},
    {1'b0, 1'b0, 1'b1, 8'h00, 16'hFFFF, 8'h5A, 8'h22},
    {1'b1, 1'b0, 1'b0, 8'h81, 16'h4321, 8'h00, 8'h99},
    {1'b0, 1'b0, 1'b0, 8'h42, 16'h8001, 8'h6B, 8'h33},
    {1'b1, 1'b1, 1'b1, 8'h01, 16'hA0A0, 8'h00, 8'hE7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [42:0] v);
    logic       r, d, p, val;
    logic [7:0] bk, wd, rd;
    logic [15:0] lo;
    {r, d, p, bk, lo, wd, rd} = v;
    val = d | p;
    @(negedge clk);
    phi2 = 1'b0; rw_n = r; vda = d; vpa = p; addr_lo = lo;
    cpu_d_in = bk; sys_d_in = rd;           // memory answers early
    @(posedge clk); #1;
    check("R1 bank phase addr", sys_addr, {bk, lo});
    check("R6 bank phase cpu_oe", cpu_d_oe, 0);
    check("R6 bank phase sys_oe", sys_d_oe, 0);
    check(val ? "R8 cs" : "R7 cs idle", mem_cs, val);
    @(negedge clk);
    phi2 = 1'b1;
    cpu_d_in = r ? ~bk : wd;                // pins change after capture
    #1;
    check("R2 bank held", sys_addr[23:16], bk);
    check("R3 low addr", sys_addr[15:0], lo);
    check(r ? "R4 cpu_oe" : "R7 cpu_oe", cpu_d_oe, val & r);
    check(r ? "R7 sys_oe" : "R5 sys_oe", sys_d_oe, val & ~r);
    check("R10 exclusive", cpu_d_oe & sys_d_oe, 0);
    if (val && r)  check("R4 read data", cpu_d_out, rd);
    if (val && !r) check("R5 write data", sys_d_out, wd);
    @(posedge clk); #1;
    check("R2 bank held after edge", sys_addr[23:16], bk);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; phi2 = 1'b1; rw_n = 1'b1; vda = 1'b1; vpa = 1'b0;
    addr_lo = 16'h5555; cpu_d_in = 8'h5A; sys_d_in = 8'h77;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset bank zero", sys_addr[23:16], 8'h00);
    check("R9 reset cs", mem_cs, 0);
    check("R9 reset cpu_oe", cpu_d_oe, 0);
    check("R9 reset sys_oe", sys_d_oe, 0);
    check("R3 low addr in reset", sys_addr[15:0], 16'h5555);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R9 sync stage quiet", mem_cs, 0);
    repeat (3) @(posedge clk); #1;
    check("R9 bank zero before capture", sys_addr[23:16], 8'h00);
    check("R8 cs after release", mem_cs, 1);
    check("R4 read oe after release", cpu_d_oe, 1);

    for (int i = 0; i < 7; i++) run_vec(VEC[i]);

    // R1: transparency follows pin changes inside bank phase
    @(negedge clk); phi2 = 1'b0; cpu_d_in = 8'h10; #1;
    check("R1 transparent before edge", sys_addr[23:16], 8'h10);
    cpu_d_in = 8'h20; #1;
    check("R1 transparent follows", sys_addr[23:16], 8'h20);
    // R6: write strobe in bank phase still drives nothing
    rw_n = 1'b0; vda = 1'b1; #1;
    check("R6 write in bank phase", sys_d_oe, 0);

    // R9: asynchronous reset mid-run
    @(negedge clk); phi2 = 1'b1; rw_n = 1'b1; #1;
    rst_n = 1'b0; #1;
    check("R9 async reset cs", mem_cs, 0);
    check("R9 async reset oe", cpu_d_oe, 0);
    check("R9 async reset bank", sys_addr[23:16], 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule